// File: doc/BRIEF.md
# Duty-Cycled Sample Scheduler

This block decides when a low-power sensor front end is powered and when it samples. It produces an awake enable, a one-cycle sample strobe at the close of every awake window, and an indication of the active timing mode and sampling rate. Two pin levels pick the mode. With both low, the block runs from its own fixed period. With the external pin high, the dual pin drives the awake and sleep states from outside. With only the dual pin high, an adaptive scheme runs at a slow rate until the sensor output changes. It then samples fast until a quiet interval has passed.

The toggle input is a pulse from the sensor's output latch whenever the latched value changes. All durations are counted in clock ticks and set by parameters. The awake window is one `AWAKE_TICKS` length in every mode.

Top module: `duty_sched`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `awake`=1, `sampleStrobe`=0, `modeInd`=2'b00 and `fastRate`=0.
- R2: `modeInd` reads 2'b00 (internal fixed period) for both pins low, 2'b01 (adaptive) for `extSel` low with `dualSel` high, and 2'b10 (external) for `extSel` high. The pins pass a two-flop synchroniser. A pin change made before clock edge 1 is shown on `modeInd` after edge 3. At that same edge a fresh awake window of `AWAKE_TICKS` cycles opens.
- R3: In internal fixed-period mode, `awake` is high for `AWAKE_TICKS` cycles and strobes repeat every `NORM_PERIOD_TICKS` cycles.
- R4: `sampleStrobe` is high for exactly one cycle, during the last awake cycle of each window. `awake` falls only in the cycle after a strobe.
- R5: In external mode with `dualSel` held high, `awake` stays high continuously and a strobe fires every `AWAKE_TICKS` cycles.
- R6: In external mode with `dualSel` held low, once the current window closes, `awake` stays low and no strobe fires.
- R7: In external mode, a rise of `dualSel` made before clock edge 1 raises `awake` after edge `DELAY_TICKS`+3. That is two synchroniser stages, the transition delay, and one state register.
- R8: In external mode, every awake window is stretched to a whole number of `AWAKE_TICKS`. With `AWAKE_TICKS`=4, a `dualSel` pulse of 1 or 4 cycles gives 4 awake cycles, and pulses of 5 or 8 cycles give 8.
- R9: On entry to adaptive mode, `fastRate`=0 and strobes repeat every `SLOW_PERIOD_TICKS` cycles.
- R10: In adaptive mode, a `toggle` pulse sets `fastRate` at the next edge. The sleep time then becomes 8×`AWAKE_TICKS`, so the period is 9×`AWAKE_TICKS`.
- R11: Every `toggle` restarts a return timer of 100×`SLOW_PERIOD_TICKS` cycles. `fastRate` stays high for exactly that many cycles after the last toggle, and then the slow period resumes.
- R12: Outside adaptive mode, `toggle` has no effect: `fastRate` stays 0 and the period is unchanged.
- R13: Leaving adaptive mode clears `fastRate` at the same edge that updates `modeInd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| extSel | input | 1 | External-control pin level (asynchronous) |
| dualSel | input | 1 | Dual-rate / external clock pin level (asynchronous) |
| toggle | input | 1 | One-cycle pulse when the sensor output changes |
| awake | output | 1 | Sensor powered and sampling |
| sampleStrobe | output | 1 | Last cycle of an awake window |
| modeInd | output | 2 | Active mode: 00 internal, 01 adaptive, 10 external |
| fastRate | output | 1 | Adaptive mode is in the fast sampling state |

## Verification
A pin change shows up on `modeInd` and opens an awake window three edges later. A `dualSel` rise in external mode reaches `awake` after `DELAY_TICKS`+3 edges. A toggle sets `fastRate` one edge later, and `fastRate` drops 100 slow periods after the last toggle. The bench drives every input on the falling clock edge and samples on the falling edge as well. It counts edges from the stimulus to the response and compares the count with these figures. Periods, window lengths and timer spans are measured as whole cycle counts between strobe or level events, so each check depends only on the parameter values.

// File: rtl/duty_sched_pkg.sv
package duty_sched_pkg;

  typedef enum logic [1:0] {
    MODE_NORM = 2'b00,
    MODE_DUAL = 2'b01,
    MODE_EXT  = 2'b10
  } modeT;

  // control -> datapath strobes
  typedef struct packed {
    logic cntClr;
    logic retClr;
    logic retRun;
  } dpCtlT;

  // datapath -> control status
  typedef struct packed {
    logic [1:0] pinSync;   // {ext, dual} after synchroniser
    logic       extReq;    // delayed dual level for external mode
    logic       awakeLast;
    logic       normDone;
    logic       slowDone;
    logic       fastDone;
    logic       retExpire;
  } dpStatT;

endpackage

// File: rtl/duty_sched_dp.sv
module duty_sched_dp
  import duty_sched_pkg::*;
#(
  parameter int AWAKE_TICKS       = 4,
  parameter int NORM_PERIOD_TICKS = 32,
  parameter int SLOW_PERIOD_TICKS = 48,
  parameter int RETURN_PERIODS    = 100,
  parameter int DELAY_TICKS       = 3
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   extSel,
  input  logic   dualSel,
  input  dpCtlT  ctl,
  output dpStatT stat
);
  localparam int NORM_SLEEP = NORM_PERIOD_TICKS - AWAKE_TICKS;
  localparam int SLOW_SLEEP = SLOW_PERIOD_TICKS - AWAKE_TICKS;
  localparam int FAST_SLEEP = 8 * AWAKE_TICKS;
  localparam int RET_TICKS  = RETURN_PERIODS * SLOW_PERIOD_TICKS;
  localparam int MAX_A      = (NORM_SLEEP > SLOW_SLEEP) ? NORM_SLEEP : SLOW_SLEEP;
  localparam int MAX_LEN    = (MAX_A > FAST_SLEEP) ? MAX_A : FAST_SLEEP;
  localparam int CNT_W      = $clog2(MAX_LEN + 1) + 1;
  localparam int RET_W      = $clog2(RET_TICKS + 1);
  localparam logic [CNT_W-1:0] AWAKE_LAST = CNT_W'(AWAKE_TICKS - 1);
  localparam logic [CNT_W-1:0] NORM_LAST  = CNT_W'(NORM_SLEEP - 1);
  localparam logic [CNT_W-1:0] SLOW_LAST  = CNT_W'(SLOW_SLEEP - 1);
  localparam logic [CNT_W-1:0] FAST_LAST  = CNT_W'(FAST_SLEEP - 1);
  localparam logic [RET_W-1:0] RET_LAST   = RET_W'(RET_TICKS - 1);

  logic [1:0]             syncA, syncB;
  logic [DELAY_TICKS-1:0] dly;
  logic [CNT_W-1:0]       phaseCnt;
  logic [RET_W-1:0]       retCnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      syncA <= '0;
      syncB <= '0;
    end else begin
      syncA <= {extSel, dualSel};
      syncB <= syncA;
    end
  end

  // fixed transition delay line on the synchronised dual level
  genvar gi;
  generate
    for (gi = 0; gi < DELAY_TICKS; gi++) begin : g_dly
      if (gi == 0) begin : g_head
        always_ff @(posedge clk) begin
          if (rst) dly[0] <= 1'b0;
          else     dly[0] <= syncB[0];
        end
      end else begin : g_tail
        always_ff @(posedge clk) begin
          if (rst) dly[gi] <= 1'b0;
          else     dly[gi] <= dly[gi-1];
        end
      end
    end
  endgenerate

  // phase counter: saturates so an open-ended external sleep is safe
  always_ff @(posedge clk) begin
    if (rst || ctl.cntClr)                 phaseCnt <= '0;
    else if (phaseCnt != {CNT_W{1'b1}})    phaseCnt <= phaseCnt + 1'b1;
  end

  // return timer for the fast sampling state
  always_ff @(posedge clk) begin
    if (rst || ctl.retClr)                 retCnt <= '0;
    else if (ctl.retRun && retCnt != RET_LAST) retCnt <= retCnt + 1'b1;
  end

  always_comb begin
    stat.pinSync   = syncB;
    stat.extReq    = dly[DELAY_TICKS-1];
    stat.awakeLast = (phaseCnt == AWAKE_LAST);
    stat.normDone  = (phaseCnt >= NORM_LAST);
    stat.slowDone  = (phaseCnt >= SLOW_LAST);
    stat.fastDone  = (phaseCnt >= FAST_LAST);
    stat.retExpire = (retCnt == RET_LAST);
  end

endmodule

// File: rtl/duty_sched_ctrl.sv
module duty_sched_ctrl
  import duty_sched_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       toggle,
  input  dpStatT     stat,
  output dpCtlT      ctl,
  output logic       awake,
  output logic       sampleStrobe,
  output logic [1:0] modeInd,
  output logic       fastRate
);
  modeT modeReg, modeNow;
  logic awakeReg, awakeNxt;
  logic fastReg, fastNxt;
  logic modeChg, sleepDone;

  always_comb begin
    casez (stat.pinSync)
      2'b1?:   modeNow = MODE_EXT;
      2'b01:   modeNow = MODE_DUAL;
      default: modeNow = MODE_NORM;
    endcase
  end

  always_comb begin
    modeChg   = (modeNow != modeReg);
    sleepDone = (modeReg == MODE_DUAL) ? (fastReg ? stat.fastDone : stat.slowDone)
                                       : stat.normDone;
    ctl        = '0;
    ctl.retRun = fastReg;
    awakeNxt   = awakeReg;
    fastNxt    = fastReg;

    if (modeChg) begin
      awakeNxt   = 1'b1;
      ctl.cntClr = 1'b1;
    end else if (awakeReg) begin
      if (stat.awakeLast) begin
        ctl.cntClr = 1'b1;
        awakeNxt   = (modeReg == MODE_EXT) && stat.extReq;
      end
    end else if (modeReg == MODE_EXT) begin
      if (stat.extReq) begin
        awakeNxt   = 1'b1;
        ctl.cntClr = 1'b1;
      end
    end else if (sleepDone) begin
      awakeNxt   = 1'b1;
      ctl.cntClr = 1'b1;
    end

    if (modeChg) begin
      fastNxt    = 1'b0;
      ctl.retClr = 1'b1;
    end else if (modeReg == MODE_DUAL && toggle) begin
      fastNxt    = 1'b1;
      ctl.retClr = 1'b1;
    end else if (fastReg && stat.retExpire) begin
      fastNxt    = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      modeReg  <= MODE_NORM;
      awakeReg <= 1'b1;
      fastReg  <= 1'b0;
    end else begin
      modeReg  <= modeNow;
      awakeReg <= awakeNxt;
      fastReg  <= fastNxt;
    end
  end

  assign awake        = awakeReg;
  assign sampleStrobe = awakeReg && stat.awakeLast && !modeChg;
  assign modeInd      = modeReg;
  assign fastRate     = fastReg;

endmodule

// File: rtl/duty_sched.sv
module duty_sched
  import duty_sched_pkg::*;
#(
  parameter int AWAKE_TICKS       = 4,
  parameter int NORM_PERIOD_TICKS = 32,
  parameter int SLOW_PERIOD_TICKS = 48,
  parameter int RETURN_PERIODS    = 100,
  parameter int DELAY_TICKS       = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       extSel,
  input  logic       dualSel,
  input  logic       toggle,
  output logic       awake,
  output logic       sampleStrobe,
  output logic [1:0] modeInd,
  output logic       fastRate
);
  dpCtlT  ctl;
  dpStatT stat;

  duty_sched_dp #(
    .AWAKE_TICKS      (AWAKE_TICKS),
    .NORM_PERIOD_TICKS(NORM_PERIOD_TICKS),
    .SLOW_PERIOD_TICKS(SLOW_PERIOD_TICKS),
    .RETURN_PERIODS   (RETURN_PERIODS),
    .DELAY_TICKS      (DELAY_TICKS)
  ) u_dp (
    .clk    (clk),
    .rst    (rst),
    .extSel (extSel),
    .dualSel(dualSel),
    .ctl    (ctl),
    .stat   (stat)
  );

  duty_sched_ctrl u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .toggle      (toggle),
    .stat        (stat),
    .ctl         (ctl),
    .awake       (awake),
    .sampleStrobe(sampleStrobe),
    .modeInd     (modeInd),
    .fastRate    (fastRate)
  );

endmodule

// File: rtl/duty_sched_chk.sv
module duty_sched_chk (
  input logic       clk,
  input logic       rst,
  input logic       toggle,
  input logic       awake,
  input logic       sampleStrobe,
  input logic [1:0] modeInd,
  input logic       fastRate
);
  // R4
  strobe_in_awake_chk: assert property (@(posedge clk) disable iff (rst)
    sampleStrobe |-> awake);

  // R4
  strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
    sampleStrobe |=> !sampleStrobe);

  // R4
  sleep_after_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(awake) |-> $past(sampleStrobe));

  // R2
  mode_fresh_window_chk: assert property (@(posedge clk) disable iff (rst)
    (modeInd != $past(modeInd)) |-> awake);

  // R10
  fast_needs_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(fastRate) |-> $past(toggle));

  // R13
  fast_only_dual_chk: assert property (@(posedge clk) disable iff (rst)
    fastRate |-> (modeInd == 2'b01));
endmodule

bind duty_sched duty_sched_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .toggle      (toggle),
  .awake       (awake),
  .sampleStrobe(sampleStrobe),
  .modeInd     (modeInd),
  .fastRate    (fastRate)
);

// File: tb/duty_sched_bench.sv
module duty_sched_bench;
  localparam int AW   = 4;
  localparam int NORM = 32;
  localparam int SLOW = 48;
  localparam int DLY  = 3;
  localparam int RET  = 100 * SLOW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic extSel = 1'b0, dualSel = 1'b0, toggle = 1'b0;
  logic awake, sampleStrobe, fastRate;
  logic [1:0] modeInd;
  int nChecks = 0, nFails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  duty_sched u_duty_sched (
    .clk(clk), .rst(rst), .extSel(extSel), .dualSel(dualSel), .toggle(toggle),
    .awake(awake), .sampleStrobe(sampleStrobe), .modeInd(modeInd), .fastRate(fastRate)
  );

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic waitStrobe();
    for (int g = 0; g < 20000 && !sampleStrobe; g++) cyc(1);
  endtask

  task automatic strobeGap(output int n);
    waitStrobe();
    cyc(1);
    n = 1;
    while (!sampleStrobe && n < 20000) begin cyc(1); n++; end
  endtask

  task automatic tReset();
    rst = 1'b1; cyc(3);
    check("R1 awake", int'(awake), 1);
    check("R1 strobe", int'(sampleStrobe), 0);
    check("R1 mode", int'(modeInd), 0);
    rst = 1'b0;
    check("R1 fast", int'(fastRate), 0);
  endtask

  task automatic tNormal();
    int g, n;
    strobeGap(g);
    check("R3 period", g, NORM);
    // strobe is last awake cycle
    check("R4 strobe awake", int'(awake), 1);
    cyc(1);
    check("R4 strobe width", int'(sampleStrobe), 0);
    check("R4 asleep after", int'(awake), 0);
    while (!awake) cyc(1);
    n = 0;
    while (awake && n < 100) begin n++; cyc(1); end
    check("R3 awake len", n, AW);
  endtask

  task automatic tToggleIgnored();
    int g;
    toggle = 1'b1; cyc(1); toggle = 1'b0; cyc(1);
    check("R12 fast stays 0", int'(fastRate), 0);
    strobeGap(g);
    check("R12 period", g, NORM);
  endtask

  task automatic tModeRestart();
    int n;
    waitStrobe(); cyc(1);
    dualSel = 1'b1;
    cyc(2);
    check("R2 sync latency awake", int'(awake), 0);
    check("R2 sync latency mode", int'(modeInd), 0);
    cyc(1);
    check("R2 fresh window", int'(awake), 1);
    check("R2 mode dual", int'(modeInd), 1);
    n = 0;
    while (awake && n < 100) begin n++; cyc(1); end
    check("R2 window len", n, AW);
  endtask

  task automatic tDualRates();
    int g, n, s1, s2;
    strobeGap(g);
    check("R9 slow period", g, SLOW);
    check("R9 fast 0", int'(fastRate), 0);
    toggle = 1'b1; cyc(1); toggle = 1'b0;
    check("R10 fast set", int'(fastRate), 1);
    n = 0; s1 = -1; s2 = -1;
    while (fastRate && n < 20000) begin
      n++;
      if (sampleStrobe && n > SLOW) begin
        if (s1 < 0) s1 = n; else if (s2 < 0) s2 = n;
      end
      cyc(1);
    end
    check("R10 fast period", s2 - s1, 9 * AW);
    check("R11 timeout", n, RET);
    strobeGap(g); strobeGap(g);
    check("R11 back to slow", g, SLOW);
    // retrigger
    toggle = 1'b1; cyc(1); toggle = 1'b0;
    n = 0;
    while (fastRate && n < 20000) begin
      n++; toggle = (n == 1000); cyc(1);
    end
    toggle = 1'b0;
    check("R11 retrigger", n, 1000 + RET);
  endtask

  task automatic tLeaveDual();
    toggle = 1'b1; cyc(1); toggle = 1'b0;
    check("R13 fast before leave", int'(fastRate), 1);
    dualSel = 1'b0; cyc(3);
    check("R13 fast cleared", int'(fastRate), 0);
    check("R13 mode normal", int'(modeInd), 0);
  endtask

  task automatic tExtCont();
    int bad, g;
    extSel = 1'b1; dualSel = 1'b1; cyc(3);
    check("R2 mode ext", int'(modeInd), 2);
    cyc(10);
    bad = 0;
    for (int i = 0; i < 100; i++) begin if (!awake) bad++; cyc(1); end
    check("R5 stays awake", bad, 0);
    strobeGap(g);
    check("R5 strobe interval", g, AW);
  endtask

  task automatic tExtSleep();
    int bad;
    dualSel = 1'b0; cyc(20);
    bad = 0;
    for (int i = 0; i < 100; i++) begin
      if (awake || sampleStrobe) bad++;
      cyc(1);
    end
    check("R6 held asleep", bad, 0);
  endtask

  task automatic tExtPulse(input int len, input int expRun);
    int rise, run;
    rise = -1; run = 0;
    dualSel = 1'b1;
    for (int n = 1; n <= 60; n++) begin
      cyc(1);
      if (n == len) dualSel = 1'b0;
      if (awake) begin
        if (rise < 0) rise = n;
        run++;
      end
    end
    check("R7 rise delay", rise, DLY + 3);
    check("R8 stretched window", run, expRun);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    cyc(1);
    tReset();
    tNormal();
    tToggleIgnored();
    tModeRestart();
    tDualRates();
    tLeaveDual();
    tExtCont();
    tExtSleep();
    tExtPulse(1, AW);
    tExtPulse(4, AW);
    tExtPulse(5, 2 * AW);
    tExtPulse(8, 2 * AW);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule